// File: doc/BRIEF.md
# Symbol-Boundary Peak Estimator

This block runs once a chirp receiver has finished filling its 200-cell energy memory during synchronization. On a start pulse it walks the memory through a read-only port, one cell per clock. It smooths the energy profile with a five-point moving average and keeps the position of the strongest smoothed value. It then decides whether that value is strong enough to count as a detection.

The winning position is then corrected for the samples that each 50-sample sub-chirp window loses to oscillator settling and redundant overlap. The corrected position is turned into a signed symbol-boundary offset. While the block works, it raises a busy flag that tells the receiver to hold off reception. When it finishes, it gives a one-cycle completion pulse. The offset, the winning position, the smoothed peak and the detection flag then stay steady until the next run. Realigning the local oscillator and checking the payload are left to other blocks.

Top module: `boundary_peak_estimator`

## Requirements
- R1: After reset, busy, done, detected and rd_en are 0, and peak_index, peak_sum and offset are 0.
- R2: A start pulse seen while idle raises busy from the next cycle. It then issues exactly 200 reads, at rd_addr 0, 1, …, 199 in that order, and each read's data is taken from rd_data one cycle after rd_en. The block has no way to write the memory.
- R3: The smoothed value at position c is the plain, unscaled sum of cells c−2 … c+2, where any cell outside 0–199 counts as zero. peak_sum reports the smoothed value at the winning position.
- R4: The winning position is the one with the largest smoothed value. If several positions share that value, the lowest position wins.
- R5: detected is 1 only when peak_sum is strictly greater than the threshold. The threshold used is the value present on the cycle that start was accepted; later changes to the threshold input have no effect on that run.
- R6: With idx the winning position and w = floor(idx/50), the corrected position equals (idx − 17·w)·50/33 rounded to the nearest integer.
- R7: offset is the corrected position minus 100, as a two's-complement value in units of 1/200 of a symbol.
- R8: done pulses for exactly one cycle, and busy falls in that same cycle. The time from start to done is at most 800 clocks, which is 80 sample periods at 10 clocks per sample.
- R9: A start pulse while busy is ignored. The run in progress is not restarted, its reads keep their order, and only one done follows.
- R10: detected, peak_index, peak_sum and offset change only in the cycle where done is 1, and they hold their values between runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one estimation run (ignored while busy) |
| threshold | input | 20 | Detection level compared against the smoothed peak |
| rd_en | output | 1 | Energy memory read strobe |
| rd_addr | output | 8 | Energy memory read address |
| rd_data | input | 17 | Energy memory read data, valid one cycle after rd_en |
| busy | output | 1 | Run in progress; reception should be paused |
| done | output | 1 | One-cycle completion pulse |
| detected | output | 1 | Smoothed peak exceeded the threshold |
| peak_index | output | 8 | Winning position of the smoothed profile |
| peak_sum | output | 20 | Smoothed value at the winning position |
| offset | output | 10 | Signed boundary offset in 1/200 symbol units |

## Verification
A lone spike tests the tie rule. It spreads into five equal smoothed values, so only the lowest-position rule yields the expected winner. Spikes at position 0 and position 199 show whether the zero padding beyond the array edges is handled. A peak inside the unused tail of a sub-chirp window, and peaks in windows two and four, separate correct piecewise correction from a plain linear scaling. An all-zero profile, a full-scale profile, and a threshold equal to the peak probe the strict comparison. A second start issued mid-run, with the threshold changed at the same time, shows whether the first run's threshold and read order survive.

// File: rtl/bpe_pkg.sv
package bpe_pkg;

  localparam int unsigned CELLS_DEF       = 200;
  localparam int unsigned WIN_DEF         = 50;
  localparam int unsigned UNUSED_DEF      = 17;
  localparam int unsigned CELL_W_DEF      = 17;
  localparam int unsigned TAPS_DEF        = 5;
  localparam int unsigned FRAC_DEF        = 12;
  localparam int unsigned SAMPLE_CLKS_DEF = 10;
  localparam int unsigned BUDGET_SMP_DEF  = 80;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_DRAIN = 2'd2
  } bpe_state_e;

  // Fixed-point gain win/(win-unused), rounded, with frac fractional bits
  function automatic int unsigned stretch_gain(int unsigned win, int unsigned unused,
                                               int unsigned frac);
    int unsigned valid;
    valid = win - unused;
    return ((win << frac) + valid / 2) / valid;
  endfunction

  // Remove the unused samples of every earlier window, then stretch
  function automatic int unsigned corrected_pos(int unsigned idx, int unsigned win,
                                                int unsigned unused, int unsigned frac);
    int unsigned wnd;
    int unsigned kept;
    wnd  = idx / win;
    kept = idx - unused * wnd;
    return (kept * stretch_gain(win, unused, frac) + (1 << (frac - 1))) >> frac;
  endfunction

endpackage

// File: rtl/bpe_window.sv
module bpe_window #(
  parameter int unsigned CELL_W = 17,
  parameter int unsigned TAPS   = 5,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned POS_W  = 9,
  parameter int unsigned SUM_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             in_vld,
  input  logic [CELL_W-1:0] in_data,
  input  logic [POS_W-1:0] in_pos,
  output logic             out_vld,
  output logic [IDX_W-1:0] out_ctr,
  output logic [SUM_W-1:0] out_sum
);
  localparam int unsigned HALF = TAPS / 2;

  logic [CELL_W-1:0] tap [TAPS];

  generate
    for (genvar g = 0; g < TAPS; g++) begin : g_tap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      tap[g] <= '0;
        else if (clear)  tap[g] <= '0;
        else if (in_vld) begin
          if (g == 0) tap[g] <= in_data;
          else        tap[g] <= tap[(g == 0) ? 0 : g - 1];
        end
      end
    end
  endgenerate

  always_comb begin
    out_sum = '0;
    for (int k = 0; k < TAPS; k++) out_sum = out_sum + SUM_W'(tap[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_ctr <= '0;
    end else if (clear) begin
      out_vld <= 1'b0;
      out_ctr <= '0;
    end else begin
      out_vld <= in_vld && (in_pos >= POS_W'(HALF));
      out_ctr <= IDX_W'(in_pos - POS_W'(HALF));
    end
  end
endmodule

// File: rtl/bpe_peak.sv
module bpe_peak #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned SUM_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             cand_vld,
  input  logic [IDX_W-1:0] cand_idx,
  input  logic [SUM_W-1:0] cand_sum,
  output logic [IDX_W-1:0] best_idx,
  output logic [SUM_W-1:0] best_sum,
  output logic             take_new
);
  // strict compare: an equal later value never displaces the earlier one
  assign take_new = cand_vld && (cand_sum > best_sum);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_idx <= '0;
      best_sum <= '0;
    end else if (clear) begin
      best_idx <= '0;
      best_sum <= '0;
    end else if (take_new) begin
      best_idx <= cand_idx;
      best_sum <= cand_sum;
    end
  end
endmodule

// File: rtl/bpe_correct.sv
module bpe_correct
  import bpe_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned OFF_W  = 10,
  parameter int unsigned CELLS  = 200,
  parameter int unsigned WIN    = 50,
  parameter int unsigned UNUSED = 17,
  parameter int unsigned FRAC   = 12
) (
  input  logic [IDX_W-1:0]        idx,
  output logic signed [OFF_W-1:0] offset
);
  localparam int unsigned CENTER = CELLS / 2;

  int unsigned adj;

  always_comb begin
    adj    = corrected_pos(32'(idx), WIN, UNUSED, FRAC);
    offset = OFF_W'(signed'(adj) - signed'(CENTER));
  end
endmodule

// File: rtl/boundary_peak_estimator.sv
module boundary_peak_estimator
  import bpe_pkg::*;
#(
  parameter int unsigned CELLS       = CELLS_DEF,
  parameter int unsigned WIN         = WIN_DEF,
  parameter int unsigned UNUSED      = UNUSED_DEF,
  parameter int unsigned CELL_W      = CELL_W_DEF,
  parameter int unsigned TAPS        = TAPS_DEF,
  parameter int unsigned FRAC        = FRAC_DEF,
  parameter int unsigned SAMPLE_CLKS = SAMPLE_CLKS_DEF,
  parameter int unsigned BUDGET_SMP  = BUDGET_SMP_DEF,
  parameter int unsigned IDX_W       = $clog2(CELLS),
  parameter int unsigned SUM_W       = CELL_W + $clog2(TAPS),
  parameter int unsigned OFF_W       = IDX_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [SUM_W-1:0]        threshold,
  output logic                    rd_en,
  output logic [IDX_W-1:0]        rd_addr,
  input  logic [CELL_W-1:0]       rd_data,
  output logic                    busy,
  output logic                    done,
  output logic                    detected,
  output logic [IDX_W-1:0]        peak_index,
  output logic [SUM_W-1:0]        peak_sum,
  output logic signed [OFF_W-1:0] offset
);
  localparam int unsigned HALF   = TAPS / 2;
  localparam int unsigned POS_W  = IDX_W + 1;
  localparam int unsigned LAST   = CELLS + HALF - 1;
  localparam int unsigned DRAIN  = 2;

  bpe_state_e       state;
  logic [POS_W-1:0] cnt;
  logic [1:0]       dcnt;
  logic [SUM_W-1:0] thr_q;

  // named internal events
  logic accept_start;
  logic scan_end;
  logic finish;

  logic             f_vld, f_pad;
  logic [POS_W-1:0] f_pos;

  logic             w_vld;
  logic [IDX_W-1:0] w_ctr;
  logic [SUM_W-1:0] w_sum;

  logic [IDX_W-1:0]        b_idx;
  logic [SUM_W-1:0]        b_sum;
  logic                    b_take;
  logic signed [OFF_W-1:0] c_off;

  assign accept_start = (state == ST_IDLE) && start;
  assign scan_end     = (state == ST_SCAN) && (cnt == POS_W'(LAST));
  assign finish       = (state == ST_DRAIN) && (dcnt == 2'(DRAIN));

  assign rd_en   = (state == ST_SCAN) && (cnt < POS_W'(CELLS));
  assign rd_addr = IDX_W'(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      dcnt  <= '0;
      thr_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      f_vld <= 1'b0;
      f_pad <= 1'b0;
      f_pos <= '0;
    end else begin
      done  <= 1'b0;
      f_vld <= 1'b0;
      case (state)
        ST_IDLE: if (accept_start) begin
          state <= ST_SCAN;
          cnt   <= '0;
          thr_q <= threshold;
          busy  <= 1'b1;
        end
        ST_SCAN: begin
          f_vld <= 1'b1;
          f_pad <= (cnt >= POS_W'(CELLS));
          f_pos <= cnt;
          cnt   <= cnt + 1'b1;
          if (scan_end) begin
            state <= ST_DRAIN;
            dcnt  <= '0;
          end
        end
        ST_DRAIN: begin
          dcnt <= dcnt + 1'b1;
          if (finish) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  bpe_window #(
    .CELL_W(CELL_W), .TAPS(TAPS), .IDX_W(IDX_W), .POS_W(POS_W), .SUM_W(SUM_W)
  ) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept_start),
    .in_vld (f_vld),
    .in_data(f_pad ? '0 : rd_data),
    .in_pos (f_pos),
    .out_vld(w_vld),
    .out_ctr(w_ctr),
    .out_sum(w_sum)
  );

  bpe_peak #(.IDX_W(IDX_W), .SUM_W(SUM_W)) u_peak (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept_start),
    .cand_vld(w_vld),
    .cand_idx(w_ctr),
    .cand_sum(w_sum),
    .best_idx(b_idx),
    .best_sum(b_sum),
    .take_new(b_take)
  );

  bpe_correct #(
    .IDX_W(IDX_W), .OFF_W(OFF_W), .CELLS(CELLS), .WIN(WIN), .UNUSED(UNUSED), .FRAC(FRAC)
  ) u_correct (
    .idx   (b_idx),
    .offset(c_off)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      detected   <= 1'b0;
      peak_index <= '0;
      peak_sum   <= '0;
      offset     <= '0;
    end else if (finish) begin
      detected   <= (b_sum > thr_q);
      peak_index <= b_idx;
      peak_sum   <= b_sum;
      offset     <= c_off;
    end
  end
endmodule

// File: rtl/bpe_checker.sv
module bpe_checker #(
  parameter int unsigned CELLS  = 200,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned BUDGET = 800
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             rd_en,
  input logic [IDX_W-1:0] rd_addr,
  input logic             busy,
  input logic             done,
  input logic             detected,
  input logic [IDX_W-1:0] peak_index,
  input logic             b_take
);
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  // R2
  rd_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);

  // R2
  rd_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr < IDX_W'(CELLS)));

  // R2
  rd_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en) && $past(busy)) |-> (rd_addr == $past(rd_addr) + 1'b1));

  // R8
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  within_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= BUDGET);

  // R9
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R10
  hold_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(detected) && $stable(peak_index)));

  // R4
  no_take_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_take |-> busy);
endmodule

bind boundary_peak_estimator bpe_checker #(
  .CELLS (CELLS),
  .IDX_W (IDX_W),
  .BUDGET(SAMPLE_CLKS * BUDGET_SMP)
) u_bpe_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .busy      (busy),
  .done      (done),
  .detected  (detected),
  .peak_index(peak_index),
  .b_take    (b_take)
);

// File: tb/tb_boundary_peak_estimator.sv
module tb_boundary_peak_estimator;
  localparam int N      = 200;
  localparam int BUDGET = 800;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [19:0]       threshold = '0;
  logic              rd_en;
  logic [7:0]        rd_addr;
  logic [16:0]       rd_data;
  logic              busy, done, detected;
  logic [7:0]        peak_index;
  logic [19:0]       peak_sum;
  logic signed [9:0] offset;

  logic [16:0] mem [N];
  int rd_cnt = 0, rd_bad = 0, done_cnt = 0;
  int n_chk = 0, n_bad = 0;
  bit timed_out = 0;

  always #2 clk = ~clk;

  boundary_peak_estimator dut (
    .clk(clk), .rst_n(rst_n), .start(start), .threshold(threshold),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done), .detected(detected),
    .peak_index(peak_index), .peak_sum(peak_sum), .offset(offset)
  );

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr];
      if (int'(rd_addr) != rd_cnt % N) rd_bad <= rd_bad + 1;
      rd_cnt <= rd_cnt + 1;
    end
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference model built from the requirement text
  task automatic model(input int thr, output int e_idx, output int e_sum,
                       output int e_det, output int e_off);
    e_idx = 0; e_sum = -1;
    for (int c = 0; c < N; c++) begin
      int s = 0;
      for (int d = -2; d <= 2; d++)
        if (c + d >= 0 && c + d < N) s += int'(mem[c + d]);
      if (s > e_sum) begin e_sum = s; e_idx = c; end
    end
    begin
      int kept = e_idx - 17 * (e_idx / 50);
      int adj  = (kept * 100 + 33) / 66;
      e_off = adj - 100;
    end
    e_det = (e_sum > thr) ? 1 : 0;
  endtask

  task automatic clear_mem();
    for (int a = 0; a < N; a++) mem[a] = '0;
  endtask

  // start, optional restart attempt mid-run, wait for done, compare
  task automatic run(string tag, int thr, bit restart);
    int e_idx, e_sum, e_det, e_off, lat, r0, d0, b0;
    model(thr, e_idx, e_sum, e_det, e_off);
    r0 = rd_cnt; d0 = done_cnt; b0 = rd_bad;
    @(negedge clk); start = 1'b1; threshold = 20'(thr);
    @(negedge clk); start = 1'b0;
    lat = 1;
    check({tag, " R2 busy after start"}, int'(busy), 1);
    while (!done && lat < BUDGET + 50) begin
      if (restart && lat == 30) begin
        start = 1'b1; threshold = 20'(0);
      end else begin
        start = 1'b0;
      end
      @(negedge clk); lat++;
    end
    start = 1'b0;
    if (!done) begin
      timed_out = 1;
      check({tag, " watchdog R8"}, 0, 1);
      return;
    end
    check({tag, " R8 latency within budget"}, int'(lat <= BUDGET), 1);
    check({tag, " R8 busy low at done"}, int'(busy), 0);
    check({tag, " R4 peak_index"}, int'(peak_index), e_idx);
    check({tag, " R3 peak_sum"}, int'(peak_sum), e_sum);
    check({tag, " R5 detected"}, int'(detected), e_det);
    check({tag, " R6 R7 offset"}, int'(offset), e_off);
    @(negedge clk);
    check({tag, " R8 done one cycle"}, int'(done), 0);
    check({tag, " R2 read count"}, rd_cnt - r0, N);
    check({tag, " R2 read order"}, rd_bad - b0, 0);
    if (restart) check({tag, " R9 single done"}, done_cnt - d0, 1);
    threshold = 20'hFFFFF;
    repeat (4) @(negedge clk);
    check({tag, " R10 hold index"}, int'(peak_index), e_idx);
    check({tag, " R10 hold detect"}, int'(detected), e_det);
  endtask

  task automatic t_reset();
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 detected", int'(detected), 0);
    check("R1 rd_en", int'(rd_en), 0);
    check("R1 offset", int'(offset), 0);
    check("R1 peak_sum", int'(peak_sum), 0);
  endtask

  task automatic t_spike_tie();
    clear_mem(); mem[120] = 17'd900;       // five equal sums, lowest wins
    run("spike_tie", 500, 0);
  endtask

  task automatic t_edges();
    clear_mem(); mem[0] = 17'd300;          // padding at low edge
    run("edge_low", 100, 0);
    clear_mem(); mem[199] = 17'd700; mem[10] = 17'd200;
    run("edge_high", 100, 0);
  endtask

  task automatic t_unused_tail();
    clear_mem();
    for (int a = 40; a < 50; a++) mem[a] = 17'(a * 3);
    mem[47] = 17'd2000;                      // peak inside window tail
    run("tail_win1", 10, 0);
    clear_mem(); mem[170] = 17'd5000; mem[171] = 17'd4000;
    run("win4", 10, 0);
    clear_mem(); mem[83] = 17'd1234;
    run("win2", 10, 0);
  endtask

  task automatic t_threshold();
    clear_mem(); mem[60] = 17'd100;
    run("thr_equal", 100, 0);                // strict compare
    run("thr_below", 99, 0);
    clear_mem();
    run("all_zero", 0, 0);
  endtask

  task automatic t_full_scale();
    for (int a = 0; a < N; a++) mem[a] = 17'h1FFFF;
    run("full_scale", 655354, 0);
  endtask

  task automatic t_restart();
    clear_mem(); mem[100] = 17'd50; mem[101] = 17'd60;
    run("restart_ignored", 200, 1);          // R9: thr 200 kept, not 0
  endtask

  initial begin
    for (int a = 0; a < N; a++) mem[a] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_spike_tie();
    t_edges();
    t_unused_tail();
    t_threshold();
    t_full_scale();
    t_restart();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog R8: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule